// File: doc/BRIEF.md
# Square-Wave Baud Clock Divider

This block divides a fixed 2.4576 MHz input clock down to a square wave running at sixteen times a chosen serial bit rate, for a downstream serial unit that oversamples each bit by sixteen. A three-bit rate code picks one of seven bit rates, from 110 up to 9600 baud, and the block looks up the matching whole-number divisor.

The output toggles between a high half-period and a low half-period. When the divisor is odd, the high half is one input clock longer than the low half. A new rate code is only picked up at the start of an output period, so a half-period already running always finishes at its old length. Besides the divided clock, the block gives a one-cycle enable pulse that lines up with every rising edge of that clock. Logic running on the input clock can use this pulse in place of the divided clock.

Both divisors are parameters. The 9600-baud divisor sets the power-of-two ladder, and the 110-baud divisor defaults to 1396, the whole-number part of 2457600 / 1760. Reset is synchronous and active high.

Top module: `baud_sqwave_gen`

## Requirements
- R1: While reset is held and after it is released, the output clock is high and the tick is low. The first period after release uses the 110-baud divisor: 698 cycles high, then 698 low, then the first tick.
- R2: The rate codes map to divisors as follows: code 0 gives 1396 (110 baud), 1 gives 512 (300), 2 gives 256 (600), 3 gives 128 (1200), 4 gives 64 (2400), 5 gives 32 (4800) and 6 gives 16 (9600). Each output period lasts exactly that many input clocks.
- R3: Code 7 is not assigned and behaves exactly like code 0.
- R4: For an even divisor N, the output is high for N/2 input clocks and low for N/2 input clocks.
- R5: For an odd divisor N, the output is high for (N+1)/2 input clocks and low for (N-1)/2 input clocks.
- R6: The tick is high for exactly one input clock, in the cycle where the output clock goes from low to high, and at no other time.
- R7: The rate code is sampled only at the rising edge of the output. A change in the middle of a period leaves that period's high and low lengths unchanged, and it takes effect from the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 2.4576 MHz input clock |
| rst | input | 1 | Synchronous reset, active high |
| rate_sel | input | 3 | Rate code (see R2, R3) |
| baud16_clk | output | 1 | Square wave at 16 times the bit rate |
| baud16_tick | output | 1 | One-cycle pulse on each rising edge of baud16_clk |

## Verification
The bench steps through all eight rate codes and measures the high and low lengths of one full period in input clocks. A wrong table entry or a shift slip shows up as a doubled or halved period, and code 7 falling into an unused divisor shows up as a foreign period. A second instance, built with an odd 110-baud divisor of 1397, checks that the extra clock goes to the high half. A design that rounded the wrong way would give 698/699 instead of 699/698. The bench also changes the rate code three clocks into a 16-clock period. A design that reloads early would cut that period short or stretch it to the new rate. Finally, the bench counts the first period after reset, where a missing reset load or an off-by-one counter would move the first falling edge.

// File: rtl/baud_pkg.sv
package baud_pkg;
  localparam int unsigned RATE_CODES = 8;

  // Divisor for a rate code: code 0 and the unassigned code 7 use the
  // slow-rate divisor; codes 1..6 form a power-of-two ladder on base.
  function automatic int unsigned pick_div(input int unsigned code,
                                           input int unsigned base,
                                           input int unsigned slow);
    if (code == 0 || code >= 7) return slow;
    return base << (6 - code);
  endfunction

  function automatic int unsigned hi_len(input int unsigned n);
    return (n + 1) >> 1;
  endfunction

  function automatic int unsigned lo_len(input int unsigned n);
    return n >> 1;
  endfunction
endpackage

// File: rtl/baud_rate_rom.sv
module baud_rate_rom
  import baud_pkg::*;
#(
  parameter int unsigned DIV_W    = 11,
  parameter int unsigned BASE_DIV = 16,
  parameter int unsigned DIV_110  = 1396
) (
  input  logic [2:0]       code,
  output logic [DIV_W-1:0] hi_ld,
  output logic [DIV_W-1:0] lo_ld
);
  logic [DIV_W-1:0] hi_tab [RATE_CODES];
  logic [DIV_W-1:0] lo_tab [RATE_CODES];

  for (genvar g = 0; g < RATE_CODES; g++) begin : g_entry
    localparam int unsigned NDIV = pick_div(g, BASE_DIV, DIV_110);
    assign hi_tab[g] = DIV_W'(hi_len(NDIV) - 1);
    assign lo_tab[g] = DIV_W'(lo_len(NDIV) - 1);
  end

  assign hi_ld = hi_tab[code];
  assign lo_ld = lo_tab[code];
endmodule

// File: rtl/baud_half_cnt.sv
module baud_half_cnt #(
  parameter int unsigned DIV_W = 11,
  parameter logic [DIV_W-1:0] RST_HI = '0,
  parameter logic [DIV_W-1:0] RST_LO = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] hi_ld,
  input  logic [DIV_W-1:0] lo_ld,
  output logic             level,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] lo_hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      level   <= 1'b1;
      cnt     <= RST_HI;
      lo_hold <= RST_LO;
      tick    <= 1'b0;
    end else begin
      tick <= 1'b0;
      if (cnt == '0) begin
        if (level) begin
          level <= 1'b0;
          cnt   <= lo_hold;
        end else begin
          // reload point: the new rate code is taken only here
          level   <= 1'b1;
          cnt     <= hi_ld;
          lo_hold <= lo_ld;
          tick    <= 1'b1;
        end
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/baud_sqwave_gen.sv
module baud_sqwave_gen
  import baud_pkg::*;
#(
  parameter int unsigned DIV_W    = 11,
  parameter int unsigned BASE_DIV = 16,
  parameter int unsigned DIV_110  = 1396
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] rate_sel,
  output logic       baud16_clk,
  output logic       baud16_tick
);
  localparam logic [DIV_W-1:0] RST_HI = DIV_W'(hi_len(DIV_110) - 1);
  localparam logic [DIV_W-1:0] RST_LO = DIV_W'(lo_len(DIV_110) - 1);

  logic [DIV_W-1:0] hi_ld;
  logic [DIV_W-1:0] lo_ld;

  baud_rate_rom #(
    .DIV_W(DIV_W), .BASE_DIV(BASE_DIV), .DIV_110(DIV_110)
  ) u_rom (
    .code(rate_sel), .hi_ld(hi_ld), .lo_ld(lo_ld)
  );

  baud_half_cnt #(
    .DIV_W(DIV_W), .RST_HI(RST_HI), .RST_LO(RST_LO)
  ) u_cnt (
    .clk(clk), .rst(rst), .hi_ld(hi_ld), .lo_ld(lo_ld),
    .level(baud16_clk), .tick(baud16_tick)
  );
endmodule

// File: rtl/baud_sqwave_chk.sv
module baud_sqwave_chk #(
  parameter int unsigned BASE_DIV = 16,
  parameter int unsigned DIV_110  = 1396
) (
  input logic       clk,
  input logic       rst,
  input logic       baud16_clk,
  input logic       baud16_tick
);
  localparam int unsigned TOP_DIV  = (DIV_110 > (BASE_DIV << 5)) ? DIV_110 : (BASE_DIV << 5);
  localparam int unsigned MAX_HALF = (TOP_DIV + 1) / 2;

  logic        prev_clk;
  int unsigned run;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_clk <= 1'b1;
      run      <= 1;
    end else begin
      prev_clk <= baud16_clk;
      run      <= (baud16_clk != prev_clk) ? 1 : run + 1;
    end
  end

  // R1
  reset_state_chk: assert property (@(posedge clk) rst |=> (baud16_clk && !baud16_tick));

  // R6
  tick_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
    baud16_tick |-> (baud16_clk && !prev_clk));

  // R6
  rise_has_tick_chk: assert property (@(posedge clk) disable iff (rst)
    (baud16_clk && !prev_clk) |-> baud16_tick);

  // R6
  tick_single_chk: assert property (@(posedge clk) disable iff (rst)
    baud16_tick |=> !baud16_tick);

  // R4
  half_bound_chk: assert property (@(posedge clk) disable iff (rst)
    run <= MAX_HALF + 1);
endmodule

bind baud_sqwave_gen baud_sqwave_chk #(
  .BASE_DIV(BASE_DIV), .DIV_110(DIV_110)
) u_chk (
  .clk(clk), .rst(rst), .baud16_clk(baud16_clk), .baud16_tick(baud16_tick)
);

// File: tb/baud_sqwave_gen_test.sv
`timescale 1ns/1ps
module baud_sqwave_gen_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] sel_a = 3'd0;
  logic [2:0] sel_b = 3'd0;
  logic       out_a, tick_a, out_b, tick_b;
  logic       which = 1'b0;
  int         n_chk = 0;
  int         n_bad = 0;

  always #4 clk = ~clk;

  baud_sqwave_gen uut (
    .clk(clk), .rst(rst), .rate_sel(sel_a),
    .baud16_clk(out_a), .baud16_tick(tick_a)
  );

  baud_sqwave_gen #(.DIV_110(1397)) uut_odd (
    .clk(clk), .rst(rst), .rate_sel(sel_b),
    .baud16_clk(out_b), .baud16_tick(tick_b)
  );

  wire m_out  = which ? out_b  : out_a;
  wire m_tick = which ? tick_b : tick_a;

  function automatic int exp_div(input int code);
    if (code == 0 || code == 7) return 1396;
    return 16 << (6 - code);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_tick();
    do @(negedge clk); while (!m_tick);
  endtask

  // measure the period that starts at the current tick cycle
  task automatic measure(output int hi, output int lo, output int ticks,
                         input int chg_at, input logic [2:0] chg_sel);
    int cyc = 0;
    hi = 1; lo = 0; ticks = 0;
    forever begin
      @(negedge clk);
      cyc++;
      if (cyc == chg_at) sel_a = chg_sel;
      if (m_tick) break;
      if (m_out) hi++; else lo++;
    end
    ticks = 1;
  endtask

  initial begin
    int hi, lo, tk, cnt;
    repeat (3) @(negedge clk);
    // R1: state during reset
    check("R1 clk during reset", int'(out_a), 1);
    check("R1 tick during reset", int'(tick_a), 0);
    rst = 1'b0;
    // R1: first period after release
    cnt = 0;
    while (out_a) begin cnt++; @(negedge clk); end
    check("R1 first high length", cnt, 698);
    cnt = 0;
    while (!out_a && !tick_a) begin cnt++; @(negedge clk); end
    check("R1 first low length", cnt, 698);
    check("R1 tick at first rise", int'(tick_a), 1);

    // R2 R3 R4 R6: sweep every code
    for (int c = 0; c < 8; c++) begin
      sel_a = 3'(c);
      wait_tick();
      measure(hi, lo, tk, 0, 3'd0);
      check($sformatf("R2 period code %0d", c), hi + lo, exp_div(c));
      check($sformatf("R4 high code %0d", c), hi, exp_div(c) / 2);
      check($sformatf("R4 low code %0d", c), lo, exp_div(c) / 2);
      if (c == 7) check("R3 code 7 matches code 0", hi + lo, exp_div(0));
    end

    // R6: tick width is one cycle
    sel_a = 3'd6;
    wait_tick();
    @(negedge clk);
    check("R6 tick lasts one cycle", int'(tick_a), 0);

    // R7: change mid-period, current period keeps old length
    wait_tick();
    measure(hi, lo, tk, 3, 3'd1);
    check("R7 old high kept", hi, 8);
    check("R7 old low kept", lo, 8);
    measure(hi, lo, tk, 0, 3'd1);
    check("R7 new high after reload", hi, 256);
    check("R7 new low after reload", lo, 256);

    // R5: odd divisor instance
    which = 1'b1;
    wait_tick();
    measure(hi, lo, tk, 0, 3'd1);
    check("R5 odd high", hi, 699);
    check("R5 odd low", lo, 698);
    which = 1'b0;

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule